// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block decides whether a memory access may proceed. Each request carries an address, an access kind (read, write or instruction fetch) and a privilege flag. The block compares the request against a set of programmable regions. Each region has an aligned base, a power-of-two size, eight equal subregions that can be switched off one by one, and per-privilege access rights with a no-execute flag. Regions may overlap or nest. Where several regions cover an address, the highest-numbered one decides. One clock after the request, the block returns allow or fault, whether any region covered the address, and the number of the deciding region.

Software programs the regions through a write port, naming the target region by its index. A separate enable turns on a background map. When that map is on, privileged accesses that no region covers may proceed.

Top module: `mpu_guard`

## Requirements
- R1: Every request with `req_valid` high produces exactly one response with `rsp_valid` high on the next clock. `rsp_valid` is low in every other cycle. After reset all regions are disabled and `rsp_valid`, `rsp_allow`, `rsp_fault` are low.
- R2: A region with size code k covers the 2^k bytes whose address bits above bit k-1 equal those of its base. Base bits below k are ignored. Codes 5 to 32 are valid. A region with any other code, or with its enable clear, covers nothing.
- R3: A region is split into eight equal subregions, numbered by address bits [k-1:k-3]. A set bit n in the region's disable mask removes subregion n from the region, so lower-numbered regions or the background map decide there.
- R4: Among the regions covering an address, the highest-numbered one decides. `rsp_hit` is 1 and `rsp_region` is its number. When no region covers the address, `rsp_hit` is 0 and `rsp_region` is 0.
- R5: The access kind is encoded 0 = read, 1 = write, 2 = execute. Rights are coded 00 = no access, 01 = read-only, 10 or 11 = read-write. A privileged request uses the region's privileged field and an unprivileged request uses its user field. Reads need a non-zero code and writes need bit 1 of the code set.
- R6: An execute request is allowed only if the deciding region grants read under the request's privilege and the region's no-execute bit is clear.
- R7: Access kind 3 is reserved and always faults.
- R8: When no region covers the address, the request is allowed only if it is privileged and `bg_en` is high. Otherwise it faults.
- R9: While `rsp_valid` is high, `rsp_fault` is the inverse of `rsp_allow`. While `rsp_valid` is low, both are low.
- R10: A write with `cfg_we` high updates only the region named by `cfg_sel`. It first affects requests presented in a later cycle. A request presented in the same cycle as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one region's settings |
| cfg_sel | input | IDX_W (3) | Index of the region to write |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | ADDR_W (32) | Region base address |
| cfg_size | input | SZW (6) | Region size as log2 of bytes |
| cfg_sub_off | input | 8 | Subregion disable mask |
| cfg_ap_priv | input | 2 | Rights code for privileged requests |
| cfg_ap_user | input | 2 | Rights code for unprivileged requests |
| cfg_xn | input | 1 | No-execute flag |
| bg_en | input | 1 | Background map enable for privileged requests |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W (32) | Request address |
| req_kind | input | 2 | Access kind |
| req_priv | input | 1 | Request is privileged |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access refused |
| rsp_hit | output | 1 | Some region covered the address |
| rsp_region | output | IDX_W (3) | Number of the deciding region |

## Verification
The bench uses the defaults: eight regions and a 32-bit address. Size code 32 therefore gives a region that covers the whole address space, with subregions 512 MB wide. All eight regions can be stacked over one address, so the deciding region can be the top index 7. Invalid size codes on both sides of the valid range can be tried. The bench also writes a region in the same cycle as a request, so both orderings of configuration and use are exercised.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] AP_NONE = 2'b00;

  typedef struct packed {
    logic [1:0] ap_priv;
    logic [1:0] ap_user;
    logic       xn;
  } rgn_perm_t;

  localparam int SUB_N = 8;
  localparam int SUB_W = 3;

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 5,
  parameter int SZW      = 6
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZW-1:0]    size,
  input  logic [SUB_N-1:0]  sub_off,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic              size_ok;
  logic [ADDR_W-1:0] hi_mask;
  logic [SUB_W-1:0]  sub_idx;
  logic              same_block;

  always_comb begin
    size_ok    = (size >= SZW'(MIN_LOG2)) && (size <= SZW'(ADDR_W));
    hi_mask    = {ADDR_W{1'b1}} << size;
    same_block = ((addr ^ base) & hi_mask) == '0;
    sub_idx    = SUB_W'(addr >> (size - SZW'(SUB_W)));
    hit        = en && size_ok && same_block && !sub_off[sub_idx];
  end

endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
  parameter int RGN_N = 8,
  parameter int IDX_W = 3
) (
  input  logic [RGN_N-1:0] hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int r = 0; r < RGN_N; r++) begin
      if (hits[r]) begin
        any = 1'b1;
        idx = IDX_W'(r);
      end
    end
  end

endmodule

// File: rtl/mpu_perm_eval.sv
module mpu_perm_eval
  import mpu_pkg::*;
(
  input  logic       hit,
  input  rgn_perm_t  perm,
  input  logic [1:0] kind,
  input  logic       priv,
  input  logic       bg_en,
  output logic       allow
);

  logic [1:0] ap;
  logic       rd_ok;
  logic       wr_ok;

  always_comb begin
    ap    = priv ? perm.ap_priv : perm.ap_user;
    rd_ok = (ap != AP_NONE);
    wr_ok = ap[1];
    if (hit) begin
      case (acc_kind_e'(kind))
        ACC_READ:  allow = rd_ok;
        ACC_WRITE: allow = wr_ok;
        ACC_EXEC:  allow = rd_ok && !perm.xn;
        default:   allow = 1'b0;
      endcase
    end else begin
      allow = (acc_kind_e'(kind) != ACC_RSVD) && priv && bg_en;
    end
  end

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int RGN_N    = 8,
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 5,
  localparam int IDX_W   = (RGN_N > 1) ? $clog2(RGN_N) : 1,
  localparam int SZW     = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZW-1:0]    cfg_size,
  input  logic [7:0]        cfg_sub_off,
  input  logic [1:0]        cfg_ap_priv,
  input  logic [1:0]        cfg_ap_user,
  input  logic              cfg_xn,
  input  logic              bg_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_fault,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region
);

  // Region settings live in flops: every region is read in parallel.
  logic [RGN_N-1:0]   rg_en;
  logic [ADDR_W-1:0]  rg_base [RGN_N];
  logic [SZW-1:0]     rg_size [RGN_N];
  logic [SUB_N-1:0]   rg_sub  [RGN_N];
  rgn_perm_t          rg_perm [RGN_N];

  always_ff @(posedge clk) begin
    for (int r = 0; r < RGN_N; r++) begin
      if (rst) begin
        rg_en[r]   <= 1'b0;
        rg_base[r] <= '0;
        rg_size[r] <= '0;
        rg_sub[r]  <= '0;
        rg_perm[r] <= '0;
      end else if (cfg_we && (cfg_sel == IDX_W'(r))) begin
        rg_en[r]   <= cfg_en;
        rg_base[r] <= cfg_base;
        rg_size[r] <= cfg_size;
        rg_sub[r]  <= cfg_sub_off;
        rg_perm[r] <= '{ap_priv: cfg_ap_priv, ap_user: cfg_ap_user, xn: cfg_xn};
      end
    end
  end

  logic [RGN_N-1:0] hits;

  for (genvar g = 0; g < RGN_N; g++) begin : g_rgn
    mpu_region_match #(
      .ADDR_W   (ADDR_W),
      .MIN_LOG2 (MIN_LOG2),
      .SZW      (SZW)
    ) u_match (
      .en      (rg_en[g]),
      .base    (rg_base[g]),
      .size    (rg_size[g]),
      .sub_off (rg_sub[g]),
      .addr    (req_addr),
      .hit     (hits[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  mpu_prio_pick #(
    .RGN_N (RGN_N),
    .IDX_W (IDX_W)
  ) u_pick (
    .hits (hits),
    .any  (any_hit),
    .idx  (win_idx)
  );

  logic allow_c;

  mpu_perm_eval u_perm (
    .hit   (any_hit),
    .perm  (rg_perm[win_idx]),
    .kind  (req_kind),
    .priv  (req_priv),
    .bg_en (bg_en),
    .allow (allow_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_allow  <= req_valid && allow_c;
      rsp_fault  <= req_valid && !allow_c;
      rsp_hit    <= req_valid && any_hit;
      rsp_region <= (req_valid && any_hit) ? win_idx : '0;
    end
  end

endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bg_en,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             req_priv,
  input logic             rsp_valid,
  input logic             rsp_allow,
  input logic             rsp_fault,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_region
);

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_allow_fault_excl_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_allow != rsp_fault));

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_allow && !rsp_fault));

  assert_miss_region_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_region == '0));

  assert_rsvd_kind_faults_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=> rsp_fault);

  assert_miss_no_bg_faults_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bg_en) |=> (rsp_hit || rsp_fault));

  assert_miss_user_faults_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv) |=> (rsp_hit || rsp_fault));

endmodule

bind mpu_guard mpu_guard_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bg_en      (bg_en),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_priv   (req_priv),
  .rsp_valid  (rsp_valid),
  .rsp_allow  (rsp_allow),
  .rsp_fault  (rsp_fault),
  .rsp_hit    (rsp_hit),
  .rsp_region (rsp_region)
);

// File: tb/sim_mpu_guard.sv
`timescale 1ns/1ps
module sim_mpu_guard;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic          cfg_en = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size = '0;
  logic [7:0]    cfg_sub_off = '0;
  logic [1:0]    cfg_ap_priv = '0;
  logic [1:0]    cfg_ap_user = '0;
  logic          cfg_xn = 1'b0;
  logic          bg_en = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = '0;
  logic          req_priv = 1'b0;
  logic          rsp_valid, rsp_allow, rsp_fault, rsp_hit;
  logic [IW-1:0] rsp_region;

  always #10 clk = ~clk;

  mpu_guard u0 (.*);

  // Bench-side model of the region settings
  logic          m_en   [N];
  logic [AW-1:0] m_base [N];
  int            m_size [N];
  logic [7:0]    m_sub  [N];
  logic [1:0]    m_app  [N];
  logic [1:0]    m_apu  [N];
  logic          m_xn   [N];

  typedef struct {
    logic          allow;
    logic          hit;
    logic [IW-1:0] region;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic exp_t model(input logic [AW-1:0] a, input logic [1:0] k,
                                 input logic p, input string tag);
    exp_t e;
    logic [1:0] ap;
    e.hit = 1'b0; e.region = '0; e.allow = 1'b0; e.tag = tag;
    for (int r = 0; r < N; r++) begin
      int sz;
      sz = m_size[r];
      if (m_en[r] && sz >= 5 && sz <= 32) begin
        longint unsigned la, lb;
        int sub;
        la  = longint'(a) >> sz;
        lb  = longint'(m_base[r]) >> sz;
        sub = int'((a >> (sz - 3)) & 32'h7);
        if (la == lb && !m_sub[r][sub]) begin
          e.hit = 1'b1; e.region = IW'(r);
        end
      end
    end
    if (k == 2'd3) e.allow = 1'b0;
    else if (!e.hit) e.allow = p && bg_en;
    else begin
      ap = p ? m_app[e.region] : m_apu[e.region];
      case (k)
        2'd0: e.allow = (ap != 2'b00);
        2'd1: e.allow = ap[1];
        default: e.allow = (ap != 2'b00) && !m_xn[e.region];
      endcase
    end
    return e;
  endfunction

  task automatic cfg(input int r, input logic en, input logic [AW-1:0] b,
                     input int sz, input logic [7:0] so, input logic [1:0] app,
                     input logic [1:0] apu, input logic xn);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = IW'(r); cfg_en = en; cfg_base = b;
    cfg_size = SW'(sz); cfg_sub_off = so; cfg_ap_priv = app;
    cfg_ap_user = apu; cfg_xn = xn;
    m_en[r] = en; m_base[r] = b; m_size[r] = sz; m_sub[r] = so;
    m_app[r] = app; m_apu[r] = apu; m_xn[r] = xn;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [1:0] k,
                      input logic p, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1; req_addr = a; req_kind = k; req_priv = p;
    exp_q.push_back(model(a, k, p, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
    end
  endtask

  // Monitor: compare each response with the front of the queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R1: response without request, actual valid=1 expected valid=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          n_cmp++;
          if (rsp_allow !== e.allow || rsp_fault !== !e.allow ||
              rsp_hit !== e.hit || rsp_region !== e.region) begin
            n_bad++;
            $display("FAIL %s: actual allow=%0b fault=%0b hit=%0b rgn=%0d expected allow=%0b fault=%0b hit=%0b rgn=%0d",
                     e.tag, rsp_allow, rsp_fault, rsp_hit, rsp_region,
                     e.allow, !e.allow, e.hit, e.region);
          end
        end
      end else if (rsp_allow || rsp_fault) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: idle outputs actual allow=%0b fault=%0b expected 0/0",
                 rsp_allow, rsp_fault);
      end
    end
  end

  initial begin
    for (int r = 0; r < N; r++) begin
      m_en[r] = 0; m_base[r] = '0; m_size[r] = 0; m_sub[r] = '0;
      m_app[r] = '0; m_apu[r] = '0; m_xn[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset state actual v=%0b a=%0b f=%0b expected 0/0/0",
               rsp_valid, rsp_allow, rsp_fault);
    end

    // No regions: background behaviour (R8), reserved kind (R7)
    send(32'h1234_5678, 2'd0, 1'b0, "R8 user miss");
    send(32'h1234_5678, 2'd0, 1'b1, "R8 priv miss bg off");
    @(negedge clk); bg_en = 1'b1; req_valid = 1'b0;
    send(32'h1234_5678, 2'd1, 1'b1, "R8 priv miss bg on");
    send(32'h1234_5678, 2'd2, 1'b1, "R8 priv exec bg on");
    send(32'h1234_5678, 2'd0, 1'b0, "R8 user miss bg on");
    send(32'h1234_5678, 2'd3, 1'b1, "R7 rsvd on bg");
    idle(2);
    bg_en = 1'b0;

    // Whole space, user read-only (R2, R5, R6)
    cfg(0, 1, 32'h0, 32, 8'h00, 2'b11, 2'b01, 1'b0);
    send(32'hFFFF_FFFC, 2'd0, 1'b0, "R5 user read RO");
    send(32'h8000_0000, 2'd1, 1'b0, "R5 user write RO");
    send(32'h8000_0000, 2'd1, 1'b1, "R5 priv write RW");
    send(32'h0000_0010, 2'd2, 1'b0, "R6 user exec RO");
    send(32'h0000_0010, 2'd3, 1'b1, "R7 rsvd in region");

    // Nested 4 KB region, no user access (R4, R5)
    cfg(3, 1, 32'h2000_0000, 12, 8'h04, 2'b10, 2'b00, 1'b0);
    send(32'h2000_0004, 2'd0, 1'b0, "R4 nested user none");
    send(32'h2000_0FFF, 2'd0, 1'b1, "R4 nested top byte");
    send(32'h2000_1000, 2'd0, 1'b0, "R2 just above region");
    // Subregion 2 (bytes 0x400..0x5FF) disabled (R3)
    send(32'h2000_0400, 2'd0, 1'b0, "R3 disabled sub falls through");
    send(32'h2000_05FF, 2'd1, 1'b0, "R3 disabled sub end");
    send(32'h2000_0600, 2'd0, 1'b0, "R3 next sub live");
    send(32'h2000_03FF, 2'd0, 1'b1, "R3 prior sub live");

    // Small 32-byte region, no-execute (R6, R4)
    cfg(5, 1, 32'h2000_0040, 5, 8'h00, 2'b11, 2'b11, 1'b1);
    send(32'h2000_0050, 2'd2, 1'b1, "R6 xn exec");
    send(32'h2000_0050, 2'd1, 1'b0, "R4 small region write");
    send(32'h2000_0060, 2'd1, 1'b0, "R2 past small region");

    // Highest index wins over all others (R4)
    cfg(7, 1, 32'h2000_0000, 8, 8'h00, 2'b01, 2'b00, 1'b0);
    send(32'h2000_0050, 2'd0, 1'b1, "R4 top index wins");
    send(32'h2000_0050, 2'd1, 1'b1, "R4 top index ro write");

    // Unaligned base ignored below size (R2)
    cfg(6, 1, 32'h1000_0123, 8, 8'h00, 2'b11, 2'b11, 1'b0);
    send(32'h1000_0100, 2'd1, 1'b0, "R2 unaligned base low");
    send(32'h1000_01FF, 2'd1, 1'b0, "R2 unaligned base high");
    send(32'h1000_0200, 2'd1, 1'b0, "R2 unaligned base out");

    // Invalid size codes never match (R2)
    cfg(4, 1, 32'h3000_0000, 4, 8'h00, 2'b11, 2'b11, 1'b0);
    send(32'h3000_0000, 2'd0, 1'b1, "R2 size code 4");
    cfg(4, 1, 32'h3000_0000, 33, 8'h00, 2'b11, 2'b11, 1'b0);
    send(32'h3000_0000, 2'd0, 1'b1, "R2 size code 33");

    // Disable a region (R2) and confirm neighbour untouched (R10)
    cfg(7, 0, 32'h2000_0000, 8, 8'h00, 2'b01, 2'b00, 1'b0);
    send(32'h2000_0050, 2'd0, 1'b1, "R10 region 7 off");
    send(32'h2000_0004, 2'd0, 1'b0, "R10 region 3 unchanged");

    // Write and request in the same cycle: old setting applies (R10)
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2000_0004; req_kind = 2'd0; req_priv = 1'b0;
    exp_q.push_back(model(32'h2000_0004, 2'd0, 1'b0, "R10 same-cycle old"));
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_en = 1'b1; cfg_base = 32'h2000_0000;
    cfg_size = 6'd12; cfg_sub_off = 8'h04; cfg_ap_priv = 2'b10;
    cfg_ap_user = 2'b01; cfg_xn = 1'b0;
    m_apu[3] = 2'b01;
    send(32'h2000_0004, 2'd0, 1'b0, "R10 next-cycle new");
    idle(3);

    // Mixed stream with background on (R4, R5, R6, R8)
    bg_en = 1'b1;
    cfg(1, 1, 32'h4000_0000, 29, 8'h81, 2'b11, 2'b10, 1'b0);
    cfg(2, 1, 32'h5000_0000, 16, 8'h10, 2'b01, 2'b01, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 32'h2000_0000 | ($urandom & 32'h0000_0FFF);
        1: a = 32'h4000_0000 | ($urandom & 32'h1FFF_FFFF);
        2: a = 32'h5000_0000 | ($urandom & 32'h0000_FFFF);
        3: a = 32'h1000_0100 | ($urandom & 32'h0000_01FF);
        default: a = $urandom;
      endcase
      send(a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R5 mixed stream");
    end
    idle(4);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: responses missing actual=%0d expected=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R1: watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule